// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a deserializer that delivers one recovered line bit per clock. It collects the bits into 10-bit characters, watches the stream for the 8b/10b comma, and, when alignment is allowed, moves its word boundary so that the character holding the comma starts a new word. Each finished word is presented on a 10-bit bus with a one-cycle strobe. A flag marks every word that is a byte-aligned comma.

The comma is recognised by the seven leading bits of a character: `0011111` or `1100000` in arrival order. This covers K28.1, K28.5 and K28.7 in both running disparities. Detection is qualified by a receiver-locked input. Moving the boundary is also gated by an alignment-enable input. When the boundary moves, the comma character is sent out at once. The partly collected old word is dropped, and later words follow every ten bits from the new boundary.

Two byte clocks at half the word rate are generated, 180 degrees apart. Each strobed word comes with a rising edge on one of them, and the two take turns. After reset the first word goes with byte clock 0.

Top module: `comma_word_aligner`

## Requirements
- R1: The first bit received of a word appears at `word_out[0]`, and the last at `word_out[9]`. Unless the boundary moves, `word_stb` pulses for one cycle each time ten bits have been taken since the previous word, or since reset.
- R2: K28.5 in either disparity must be found as a comma. The check is on `word_out[6:0]`, which must equal `7'b1111100` or `7'b0000011`.
- R3: K28.1 and K28.7 must also be found as commas.
- R4: While `align_en` is 0, the word boundary does not move. A comma that is not on the boundary raises no flag.
- R5: While `rx_locked` is 0, no comma is detected, no flag is raised and the boundary does not move.
- R6: `comma_flag` is high only together with `word_stb`, and only for a word whose bits [6:0] match the comma pattern.
- R7: On each strobe, byte clock 0 toggles and byte clock 1 takes the old value of byte clock 0. Between strobes both clocks hold their value, and they are never high together.
- R8: The first word after reset rises with `byte_clk0`, while `byte_clk1` stays low.
- R9: While `rst_n` is low, `word_stb`, `comma_flag` and both byte clocks are 0, line bits are ignored, and `word_out` keeps its previous value.
- R10: A comma found off the boundary, with both alignment and lock active, is emitted as a complete flagged word on the cycle after its tenth bit. The next word follows ten bits later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered serial bit |
| align_en | input | 1 | Allows the word boundary to move onto a comma |
| rx_locked | input | 1 | Receiver locked; enables comma detection |
| word_out | output | 10 | Framed character, bit 0 received first |
| word_stb | output | 1 | One-cycle pulse with each new word |
| comma_flag | output | 1 | Word is a byte-aligned comma |
| byte_clk0 | output | 1 | Half-rate byte clock, even words |
| byte_clk1 | output | 1 | Half-rate byte clock, odd words |

## Verification
The checker tests on every cycle that the flag comes only with a strobe, only with a comma pattern and only when lock was present. It also tests that an early strobe happens only for a flagged comma with alignment enabled, that unshortened strobes keep the ten-bit spacing, and how the byte clocks move. It confirms that `word_out` holds during reset as well. The cases where a comma must be found and was missed cannot be seen by the checker. These cover each comma type and disparity, and the words that follow a slip. They show up only in the bench scenarios, which compare every cycle against the reference model and count flags in phases with alignment disabled or lock withheld.

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              align_en,
  input  logic              rx_locked,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb,
  output logic              comma_flag,
  output logic              byte_clk0,
  output logic              byte_clk1
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg, nxt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              primed;
  logic              at_edge, pat_hit, comma_now, slip, emit;

  assign nxt       = {rx_bit, shreg[WORD_W-1:1]};
  assign at_edge   = (bit_cnt == LAST);
  assign pat_hit   = (nxt[COMMA_W-1:0] == COMMA_PAT) || (nxt[COMMA_W-1:0] == ~COMMA_PAT);
  assign comma_now = rx_locked && (primed || at_edge) && pat_hit;
  assign slip      = comma_now && align_en && !at_edge;
  assign emit      = at_edge || slip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      primed     <= 1'b0;
      word_stb   <= 1'b0;
      comma_flag <= 1'b0;
      byte_clk0  <= 1'b0;
      byte_clk1  <= 1'b0;
    end else begin
      shreg      <= nxt;
      bit_cnt    <= emit ? '0 : bit_cnt + CNT_W'(1);
      primed     <= primed | at_edge;
      word_stb   <= emit;
      comma_flag <= emit && comma_now;
      if (emit) begin
        word_out  <= nxt;
        byte_clk0 <= ~byte_clk0;
        byte_clk1 <= byte_clk0;
      end
    end
  end
endmodule

module comma_word_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       align_en,
  input logic       rx_locked,
  input logic [9:0] word_out,
  input logic       word_stb,
  input logic       comma_flag,
  input logic       byte_clk0,
  input logic       byte_clk1
);
  logic [4:0] since;
  logic       first_pending;
  logic       seen, rst_was_low;
  logic [9:0] prev_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since         <= '0;
      first_pending <= 1'b1;
    end else begin
      if (word_stb) since <= 5'd1;
      else if (since != 5'd31) since <= since + 5'd1;
      if (word_stb) first_pending <= 1'b0;
    end
  end

  initial begin
    seen = 1'b0;
    rst_was_low = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n && rst_was_low && seen)
      assert_hold_in_reset_R9: assert (word_out == prev_word)
        else $error("word_out changed during reset");
    prev_word   <= word_out;
    rst_was_low <= !rst_n;
    if (word_stb) seen <= 1'b1;
  end

  assert_flag_with_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> word_stb);
  assert_flag_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> (word_out[6:0] == 7'b1111100 || word_out[6:0] == 7'b0000011));
  assert_flag_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> $past(rx_locked));
  assert_early_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && since < 5'd10) |-> (comma_flag && $past(align_en)));
  assert_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 5'd10) |-> word_stb);
  assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    since <= 5'd10);
  assert_clk_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_clk0 && byte_clk1));
  assert_clk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !$stable(byte_clk0));
  assert_clk_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> ($stable(byte_clk0) && $stable(byte_clk1)));
  assert_first_clk0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && first_pending) |-> (byte_clk0 && !byte_clk1));
endmodule

bind comma_word_aligner comma_word_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .align_en(align_en), .rx_locked(rx_locked),
  .word_out(word_out), .word_stb(word_stb), .comma_flag(comma_flag),
  .byte_clk0(byte_clk0), .byte_clk1(byte_clk1)
);

// File: tb/comma_word_aligner_tb.sv
module comma_word_aligner_tb;
  localparam logic [9:0] K285N = 10'b0101111100;
  localparam logic [9:0] K285P = 10'b1010000011;
  localparam logic [9:0] K281N = 10'b1001111100;
  localparam logic [9:0] K287N = 10'b0001111100;
  localparam logic [9:0] DAT_A = 10'b0101010101;
  localparam logic [9:0] DAT_B = 10'b1010101010;
  localparam logic [9:0] ORDER = 10'b0000110101;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_bit = 1'b0, align_en = 1'b0, rx_locked = 1'b0;
  logic [9:0] word_out;
  logic word_stb, comma_flag, byte_clk0, byte_clk1;

  always #5 clk = ~clk;

  comma_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .align_en(align_en),
    .rx_locked(rx_locked), .word_out(word_out), .word_stb(word_stb),
    .comma_flag(comma_flag), .byte_clk0(byte_clk0), .byte_clk1(byte_clk1)
  );

  int tests = 0, fails = 0;
  string req = "R9";
  int flags = 0, rise0 = 0, rise1 = 0;
  bit done = 0;

  bit hist[$];
  int nbits = 0;
  logic [9:0] e_word = 'x;
  bit e_stb = 0, e_flag = 0, e_b0 = 0, e_b1 = 0;
  logic [9:0] last_flag_word;

  task automatic check(input bit ok, input string r, input string what,
                       input logic [13:0] act, input logic [13:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic void model(bit b, bit en, bit lk, bit rst);
    logic [9:0] win;
    bit full, hit, go;
    if (rst) begin
      hist.delete(); nbits = 0;
      e_stb = 0; e_flag = 0; e_b0 = 0; e_b1 = 0;
      return;
    end
    hist.push_back(b);
    if (hist.size() > 10) void'(hist.pop_front());
    nbits++;
    full = (hist.size() == 10);
    win = 'x;
    if (full) for (int i = 0; i < 10; i++) win[i] = hist[i];
    hit = lk && full && (win[6:0] == 7'b1111100 || win[6:0] == 7'b0000011);
    go = (nbits == 10) || (hit && en);
    e_stb = go; e_flag = go && hit;
    if (go) begin
      e_word = win; nbits = 0;
      e_b1 = e_b0; e_b0 = !e_b0;
    end
  endfunction

  task automatic cyc(input bit b);
    logic b0_old, b1_old;
    rx_bit = b;
    model(b, align_en, rx_locked, !rst_n);
    b0_old = byte_clk0; b1_old = byte_clk1;
    @(negedge clk);
    check({word_out, word_stb, comma_flag, byte_clk0, byte_clk1} ===
          {e_word, e_stb, e_flag, e_b0, e_b1}, req, "cycle compare",
          {word_out, word_stb, comma_flag, byte_clk0, byte_clk1},
          {e_word, e_stb, e_flag, e_b0, e_b1});
    if (comma_flag === 1'b1) begin flags++; last_flag_word = word_out; end
    if (byte_clk0 && !b0_old) rise0++;
    if (byte_clk1 && !b1_old) rise1++;
  endtask

  task automatic send(input logic [9:0] w);
    for (int i = 0; i < 10; i++) cyc(w[i]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    @(negedge clk);
    req = "R9";
    for (int i = 0; i < 3; i++) cyc(1'b1);
    check({word_stb, comma_flag, byte_clk0, byte_clk1} == 4'b0, "R9", "reset outputs",
          {10'b0, word_stb, comma_flag, byte_clk0, byte_clk1}, 14'b0);

    rst_n = 1'b1; rx_locked = 1'b1; align_en = 1'b1;
    req = "R2"; flags = 0;
    cyc(1); cyc(0); cyc(1);
    send(DAT_A); send(DAT_A); send(K285N);
    send(DAT_A); send(DAT_A); send(DAT_A); send(K285P);
    send(DAT_A); send(DAT_A);
    check(flags == 2, "R2", "K28.5 flags", 14'(flags), 14'd2);
    req = "R10";
    check(last_flag_word == K285P, "R10", "aligned comma word", {4'b0, last_flag_word}, {4'b0, K285P});

    req = "R3"; flags = 0;
    cyc(0); cyc(1); cyc(0); cyc(1);
    send(K281N); send(DAT_A); send(DAT_A); send(K287N); send(DAT_A);
    check(flags == 2, "R3", "K28.1/K28.7 flags", 14'(flags), 14'd2);
    check(last_flag_word == K287N, "R3", "K28.7 word", {4'b0, last_flag_word}, {4'b0, K287N});

    req = "R4"; flags = 0; align_en = 1'b0;
    cyc(1); cyc(0); cyc(1);
    send(K285N); send(DAT_A); send(DAT_A); send(DAT_A); send(K285N); send(DAT_A);
    check(flags == 0, "R4", "no realign flags", 14'(flags), 14'd0);

    req = "R5"; flags = 0; align_en = 1'b1; rx_locked = 1'b0;
    cyc(1); cyc(0);
    send(K285N); send(DAT_A); send(K285P); send(DAT_A); send(DAT_A);
    check(flags == 0, "R5", "unlocked flags", 14'(flags), 14'd0);
    rx_locked = 1'b1; flags = 0;
    send(DAT_A); send(K285N); send(DAT_A);
    check(flags == 1, "R5", "flag after lock", 14'(flags), 14'd1);

    req = "R9";
    held = word_out;
    rst_n = 1'b0;
    for (int i = 0; i < 6; i++) cyc(i[0]);
    check(word_out == held, "R9", "word held in reset", {4'b0, word_out}, {4'b0, held});
    check({word_stb, byte_clk0, byte_clk1} == 3'b0, "R9", "strobe/clocks in reset",
          {11'b0, word_stb, byte_clk0, byte_clk1}, 14'b0);
    rst_n = 1'b1; align_en = 1'b0;
    req = "R1";
    send(ORDER);
    check(word_stb && word_out == ORDER, "R1", "bit order first word",
          {3'b0, word_stb, word_out}, {4'b1, ORDER});
    check(byte_clk0 && !byte_clk1, "R8", "first word on clock 0",
          {12'b0, byte_clk0, byte_clk1}, 14'b10);
    send(DAT_B);
    check(!byte_clk0 && byte_clk1, "R7", "second word on clock 1",
          {12'b0, byte_clk0, byte_clk1}, 14'b01);

    req = "R6"; flags = 0; rise0 = 0; rise1 = 0; align_en = 1'b1;
    for (int n = 0; n < 250; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) send(K285N);
      else if (sel == 1) send(K285P);
      else if (sel == 2) send(K281N);
      else if (sel == 3) send(K287N);
      else if (sel == 4) for (int j = 0; j < int'($urandom_range(1, 9)); j++) cyc(j[0]);
      else if (sel == 5) begin align_en = ~align_en; send(DAT_A); end
      else if (sel == 6) begin rx_locked = ($urandom_range(0, 3) != 0); send(DAT_B); end
      else send(DAT_A);
    end
    check(flags > 0, "R6", "random flags seen", 14'(flags), 14'd1);
    check((rise0 - rise1) <= 1 && (rise1 - rise0) <= 1, "R7", "clock rise balance",
          14'(rise0), 14'(rise1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule